// File: doc/BRIEF.md
# Pixel Region Triggered Hit Buffer

This block is the shared digital logic of a region of four adjacent pixel cells. It watches each pixel's discriminator output and measures a time-over-threshold (ToT) value for every pixel of a hit group. It then holds these values in one of a small number of local event slots until the level-1 trigger decision is due. Each slot has its own latency counter. The counter is loaded with a programmable trigger latency when the event starts and counts down every clock. If the trigger is present at the moment the counter runs out, the slot is kept for readout. Otherwise the slot is freed at once, so only triggered hits ever leave the region.

Low-amplitude hits have late discriminator timing, so their own timing is not used to decide whether they belong to the event. A small hit is kept when it falls in the same capture window as a large hit in a neighbouring pixel of the region. An event with no large hit at all is discarded. Triggered events are read out over a token chain. A region that holds the token and has triggered data keeps the token and presents one event at a time until every event has been accepted. A region without triggered data passes the token on at once. A busy output tells the surrounding logic when the region holds no state, so that its clock can be gated off.

Top module: `pixel_region_buffer`

## Requirements
- R1: After reset, rdValid and overflow are 0, regionBusy is 0 and tokenOut equals tokenIn.
- R2: A capture window opens at a clock edge that samples a rising discriminator on any pixel while no window is open. It closes at the first sampled cycle in which all discriminators are low, or after 15 samples. Each pixel's stored ToT is the number of samples in the window in which that pixel was high.
- R3: An event is stored only if at least one pixel's ToT is at least LARGE_TOT (4 by default). When it is stored, every pixel's ToT is kept, including values below LARGE_TOT. An event without such a pixel is dropped and never appears on the read interface.
- R4: A stored event is marked triggered only if l1Trig is high at the edge that comes exactly trigLatency+1 edges after its start edge. A trigger at any other edge has no effect on it, and an event with no trigger at that edge is freed.
- R5: Five event slots exist. An event that starts while all five are held is dropped, and overflow goes to 1 and stays there until reset.
- R6: While tokenIn is high and a triggered event is held, rdValid is 1 and tokenOut is 0. Otherwise rdValid is 0 and tokenOut equals tokenIn.
- R7: rdData carries pixel p's ToT in bits [4p+3:4p]. A cycle with rdValid and rdAccept both high releases the presented event. When several events are triggered, the slot with the lowest index is presented first, and slots are allocated lowest free index first.
- R8: regionBusy is 1 while a window is open or any slot is held, and 0 otherwise.
- R9: trigLatency must be at least 16 (2**TOTW), so that a window always closes before its latency expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Region clock |
| rstN | input | 1 | Asynchronous reset, active low |
| disc | input | NPIX | Per-pixel discriminator outputs |
| l1Trig | input | 1 | Level-1 trigger pulse |
| trigLatency | input | LATW | Trigger latency in clock cycles |
| tokenIn | input | 1 | Read token from the previous region |
| rdAccept | input | 1 | End-of-column accepts the presented event |
| tokenOut | output | 1 | Read token to the next region |
| rdValid | output | 1 | A triggered event is presented |
| rdData | output | NPIX*TOTW | ToT values of the presented event |
| overflow | output | 1 | Sticky flag: a hit was lost because all slots were full |
| regionBusy | output | 1 | Region holds state; its clock must run |

## Verification
The checker holds on every cycle: the token rules (no token leaves the region without one arriving, and a region presenting data keeps the token), the stickiness of overflow, the absence of read data while the region reports idle, and the floor on the trigger latency. The scenarios alone show the ToT arithmetic and the small-hit association, the exact trigger edge against triggers one edge early or late, the lowest-index read order, and the dropping of the sixth concurrent event. The sweep varies per-pixel ToT patterns, the latency and the trigger presence, and the bench computes each expected read word from the pattern.

// File: rtl/pixreg_pkg.sv
package pixreg_pkg;

  typedef enum logic [1:0] {
    SLOT_FREE,
    SLOT_MEAS,
    SLOT_WAIT,
    SLOT_TRIG
  } slotState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic winStart;  // a window opens this edge
    logic winOpen;   // a window is already open
    logic wrEn;      // commit the accumulated ToT into wrIdx
  } dpStrobe_t;

endpackage

// File: rtl/pixreg_datapath.sv
module pixreg_datapath
  import pixreg_pkg::*;
#(
  parameter int NPIX      = 4,
  parameter int NSLOT     = 5,
  parameter int TOTW      = 4,
  parameter int LARGE_TOT = 4,
  parameter int IDXW      = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NPIX-1:0]      disc,
  input  dpStrobe_t            strobe,
  input  logic [IDXW-1:0]      wrIdx,
  input  logic [IDXW-1:0]      rdIdx,
  output logic                 anyLarge,
  output logic [NPIX*TOTW-1:0] rdData
);

  logic [NPIX-1:0][TOTW-1:0] acc;
  logic [NPIX-1:0][TOTW-1:0] accNext;
  logic [NPIX*TOTW-1:0]      store [NSLOT];

  always_comb begin
    anyLarge = 1'b0;
    for (int p = 0; p < NPIX; p++) begin
      accNext[p] = (strobe.winStart ? '0 : acc[p]) + TOTW'(disc[p]);
      if (accNext[p] >= TOTW'(LARGE_TOT)) anyLarge = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) acc <= '0;
    else if (strobe.winStart || strobe.winOpen) acc <= accNext;
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn) store[wrIdx] <= accNext;
  end

  assign rdData = store[rdIdx];

endmodule

// File: rtl/pixreg_ctrl.sv
module pixreg_ctrl
  import pixreg_pkg::*;
#(
  parameter int NPIX  = 4,
  parameter int NSLOT = 5,
  parameter int TOTW  = 4,
  parameter int LATW  = 8,
  parameter int IDXW  = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NPIX-1:0] disc,
  input  logic            l1Trig,
  input  logic [LATW-1:0] trigLatency,
  input  logic            tokenIn,
  input  logic            rdAccept,
  input  logic            anyLarge,
  output dpStrobe_t       strobe,
  output logic [IDXW-1:0] wrIdx,
  output logic [IDXW-1:0] rdIdx,
  output logic            tokenOut,
  output logic            rdValid,
  output logic            overflow,
  output logic            regionBusy
);

  localparam int MAXSAMP = (1 << TOTW) - 1;

  slotState_e       slotSt [NSLOT];
  logic [LATW-1:0]  latCnt [NSLOT];
  logic [NPIX-1:0]  discPrev;
  logic             winOpen;
  logic             dropEvt;
  logic [TOTW-1:0]  winCnt;
  logic [TOTW-1:0]  cntNext;
  logic [IDXW-1:0]  measSlot;
  logic [IDXW-1:0]  allocIdx;
  logic             haveFree, hasTrig, allFree;
  logic             startEvt, closeEvt, rdDone;

  always_comb begin
    haveFree = 1'b0;
    hasTrig  = 1'b0;
    allFree  = 1'b1;
    allocIdx = '0;
    rdIdx    = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (slotSt[i] == SLOT_FREE) begin
        haveFree = 1'b1;
        allocIdx = IDXW'(i);
      end else begin
        allFree = 1'b0;
      end
      if (slotSt[i] == SLOT_TRIG) begin
        hasTrig = 1'b1;
        rdIdx   = IDXW'(i);
      end
    end
  end

  assign startEvt   = !winOpen && ((disc & ~discPrev) != '0);
  assign cntNext    = winCnt + TOTW'(1);
  assign closeEvt   = winOpen && ((disc == '0) || (cntNext == TOTW'(MAXSAMP)));
  assign rdValid    = tokenIn && hasTrig;
  assign rdDone     = rdValid && rdAccept;
  assign tokenOut   = tokenIn && !hasTrig;
  assign regionBusy = winOpen || !allFree;
  assign wrIdx      = measSlot;

  assign strobe.winStart = startEvt;
  assign strobe.winOpen  = winOpen;
  assign strobe.wrEn     = closeEvt && !dropEvt && anyLarge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      discPrev <= '0;
      winOpen  <= 1'b0;
      dropEvt  <= 1'b0;
      winCnt   <= '0;
      measSlot <= '0;
      overflow <= 1'b0;
    end else begin
      discPrev <= disc;
      if (startEvt) begin
        winOpen  <= 1'b1;
        winCnt   <= TOTW'(1);
        measSlot <= allocIdx;
        dropEvt  <= !haveFree;
        if (!haveFree) overflow <= 1'b1;
      end else if (closeEvt) begin
        winOpen <= 1'b0;
      end else if (winOpen) begin
        winCnt <= cntNext;
      end
    end
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotSt[i] <= SLOT_FREE;
        latCnt[i] <= '0;
      end else begin
        case (slotSt[i])
          SLOT_FREE: begin
            if (startEvt && haveFree && allocIdx == IDXW'(i)) begin
              slotSt[i] <= SLOT_MEAS;
              latCnt[i] <= trigLatency;
            end
          end
          SLOT_MEAS: begin
            if (latCnt[i] != '0) latCnt[i] <= latCnt[i] - LATW'(1);
            if (closeEvt && !dropEvt && measSlot == IDXW'(i))
              slotSt[i] <= anyLarge ? SLOT_WAIT : SLOT_FREE;
          end
          SLOT_WAIT: begin
            if (latCnt[i] == '0) slotSt[i] <= l1Trig ? SLOT_TRIG : SLOT_FREE;
            else latCnt[i] <= latCnt[i] - LATW'(1);
          end
          SLOT_TRIG: begin
            if (rdDone && rdIdx == IDXW'(i)) slotSt[i] <= SLOT_FREE;
          end
          default: slotSt[i] <= SLOT_FREE;
        endcase
      end
    end
  end

endmodule

// File: rtl/pixel_region_buffer.sv
module pixel_region_buffer
  import pixreg_pkg::*;
#(
  parameter int NPIX      = 4,
  parameter int NSLOT     = 5,
  parameter int TOTW      = 4,
  parameter int LATW      = 8,
  parameter int LARGE_TOT = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NPIX-1:0]      disc,
  input  logic                 l1Trig,
  input  logic [LATW-1:0]      trigLatency,
  input  logic                 tokenIn,
  input  logic                 rdAccept,
  output logic                 tokenOut,
  output logic                 rdValid,
  output logic [NPIX*TOTW-1:0] rdData,
  output logic                 overflow,
  output logic                 regionBusy
);

  localparam int IDXW = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  dpStrobe_t       strobe;
  logic [IDXW-1:0] wrIdx, rdIdx;
  logic            anyLarge;

  pixreg_ctrl #(
    .NPIX(NPIX), .NSLOT(NSLOT), .TOTW(TOTW), .LATW(LATW), .IDXW(IDXW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .disc(disc), .l1Trig(l1Trig),
    .trigLatency(trigLatency), .tokenIn(tokenIn), .rdAccept(rdAccept),
    .anyLarge(anyLarge), .strobe(strobe), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .tokenOut(tokenOut), .rdValid(rdValid), .overflow(overflow),
    .regionBusy(regionBusy)
  );

  pixreg_datapath #(
    .NPIX(NPIX), .NSLOT(NSLOT), .TOTW(TOTW), .LARGE_TOT(LARGE_TOT), .IDXW(IDXW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .disc(disc), .strobe(strobe),
    .wrIdx(wrIdx), .rdIdx(rdIdx), .anyLarge(anyLarge), .rdData(rdData)
  );

endmodule

// File: rtl/pixreg_checker.sv
module pixreg_checker #(
  parameter int TOTW = 4,
  parameter int LATW = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic [LATW-1:0] trigLatency,
  input logic            tokenIn,
  input logic            tokenOut,
  input logic            rdValid,
  input logic            overflow,
  input logic            regionBusy
);

  localparam int MIN_LAT = 1 << TOTW;

  // R6: a token can only leave when one arrived
  a_r6_token_needs_in: assert property (@(posedge clk) disable iff (!rstN)
    tokenOut |-> tokenIn);

  // R6: a region presenting data holds the token
  a_r6_hold_token: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (tokenIn && !tokenOut));

  // R6: with the token and nothing to present, it moves on
  a_r6_pass_through: assert property (@(posedge clk) disable iff (!rstN)
    (tokenIn && !rdValid) |-> tokenOut);

  // R5: overflow stays set until reset
  a_r5_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  // R8: an idle region presents nothing
  a_r8_idle_no_read: assert property (@(posedge clk) disable iff (!rstN)
    !regionBusy |-> !rdValid);

  // R9: latency floor
  a_r9_latency_floor: assert property (@(posedge clk) disable iff (!rstN)
    trigLatency >= LATW'(MIN_LAT));

endmodule

bind pixel_region_buffer pixreg_checker #(.TOTW(TOTW), .LATW(LATW)) u_chk (
  .clk(clk), .rstN(rstN), .trigLatency(trigLatency), .tokenIn(tokenIn),
  .tokenOut(tokenOut), .rdValid(rdValid), .overflow(overflow),
  .regionBusy(regionBusy)
);

// File: tb/sim_pixel_region_buffer.sv
`timescale 1ns/1ps
module sim_pixel_region_buffer;
  localparam int NPIX = 4, NSLOT = 5, TOTW = 4, LATW = 8, LARGE = 4;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic [NPIX-1:0]      disc = '0;
  logic                 l1Trig = 1'b0;
  logic [LATW-1:0]      trigLatency = 8'd16;
  logic                 tokenIn = 1'b0;
  logic                 rdAccept = 1'b0;
  logic                 tokenOut, rdValid, overflow, regionBusy;
  logic [NPIX*TOTW-1:0] rdData;

  int checks = 0, errors = 0, edgeNo = 0;
  bit done = 1'b0;
  bit trigPlan [0:4095];

  always #2.5 clk = ~clk;

  pixel_region_buffer #(.NPIX(NPIX), .NSLOT(NSLOT), .TOTW(TOTW), .LATW(LATW),
                        .LARGE_TOT(LARGE)) u0 (
    .clk(clk), .rstN(rstN), .disc(disc), .l1Trig(l1Trig),
    .trigLatency(trigLatency), .tokenIn(tokenIn), .rdAccept(rdAccept),
    .tokenOut(tokenOut), .rdValid(rdValid), .rdData(rdData),
    .overflow(overflow), .regionBusy(regionBusy)
  );

  task automatic step();
    @(posedge clk);
    #1;
    edgeNo++;
    l1Trig = trigPlan[edgeNo + 1];
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // trigOff: 0 aligned, -1 early, +1 late, 99 none
  task automatic runEvent(input int t [4], input int lat, input int trigOff);
    int s, maxT;
    bit stored, expRead;
    logic [15:0] expData;
    trigLatency = LATW'(lat);
    s = edgeNo + 1;
    if (trigOff != 99) trigPlan[s + lat + 1 + trigOff] = 1'b1;
    maxT = 0;
    expData = '0;
    for (int p = 0; p < NPIX; p++) begin
      if (t[p] > maxT) maxT = t[p];
      expData[4*p +: 4] = 4'(t[p]);
    end
    stored  = (maxT >= LARGE);
    expRead = stored && (trigOff == 0);
    for (int c = 0; c < 15; c++) begin
      for (int p = 0; p < NPIX; p++) disc[p] = (c < t[p]);
      step();
    end
    disc = '0;
    chk("R8 busy while waiting", 32'(regionBusy), 32'(stored));
    while (edgeNo < s + lat + 3) step();
    #1;
    chk("R6 no token: rdValid", 32'(rdValid), 0);
    chk("R6 no token: tokenOut", 32'(tokenOut), 0);
    tokenIn = 1'b1;
    #1;
    chk("R4/R3 rdValid after trigger edge", 32'(rdValid), 32'(expRead));
    chk("R6 tokenOut with token", 32'(tokenOut), 32'(!expRead));
    if (expRead) chk("R2/R7 rdData ToT word", 32'(rdData), 32'(expData));
    rdAccept = 1'b1;
    step();
    rdAccept = 1'b0;
    #1;
    chk("R7 released after accept", 32'(rdValid), 0);
    chk("R8 idle after release", 32'(regionBusy), 0);
    tokenIn = 1'b0;
    step();
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) trigPlan[i] = 1'b0;
    step();
    step();
    rstN = 1'b1;
    #1;
    chk("R1 reset rdValid", 32'(rdValid), 0);
    chk("R1 reset overflow", 32'(overflow), 0);
    chk("R1 reset busy", 32'(regionBusy), 0);
    tokenIn = 1'b1;
    #1;
    chk("R1 reset token pass", 32'(tokenOut), 1);
    tokenIn = 1'b0;
    step();

    // R2 R3 R4 sweep of ToT patterns, latencies and trigger presence
    for (int a = 0; a < 16; a++) begin
      int t [4];
      t[0] = a;
      t[1] = (a * 3) % 5;
      t[2] = (a + 1) % 3;
      t[3] = a >> 2;
      runEvent(t, 16 + (a % 3) * 2, (a % 4 == 3) ? 99 : 0);
    end

    // R4 misaligned triggers are ignored; R3 small hits kept beside a large one
    runEvent('{9, 2, 0, 1}, 18, -1);
    runEvent('{9, 2, 0, 1}, 18, 1);
    runEvent('{1, 15, 3, 0}, 17, 0);

    // R5 overflow and R7 read order
    begin
      int s5;
      trigLatency = 8'd60;
      s5 = 0;
      for (int k = 0; k < 6; k++) begin
        int s;
        s = edgeNo + 1;
        s5 = s;
        trigPlan[s + 61] = 1'b1;
        if (k == 5) chk("R5 overflow low before sixth", 32'(overflow), 0);
        disc = '0;
        disc[k % 4] = 1'b1;
        for (int c = 0; c < 4 + k; c++) step();
        disc = '0;
        step();
      end
      chk("R5 overflow set by sixth event", 32'(overflow), 1);
      while (edgeNo < s5 + 63) step();
      tokenIn = 1'b1;
      for (int k = 0; k < 5; k++) begin
        logic [15:0] e;
        e = '0;
        e[4*(k%4) +: 4] = 4'(4 + k);
        #1;
        chk("R7 ordered read valid", 32'(rdValid), 1);
        chk("R7 ordered read data", 32'(rdData), 32'(e));
        rdAccept = 1'b1;
        step();
        rdAccept = 1'b0;
      end
      #1;
      chk("R5 sixth event dropped", 32'(rdValid), 0);
      chk("R6 token passes when drained", 32'(tokenOut), 1);
      chk("R5 overflow sticky", 32'(overflow), 1);
      tokenIn = 1'b0;
      trigLatency = 8'd16;
      rstN = 1'b0;
      step();
      rstN = 1'b1;
      #1;
      chk("R1 overflow cleared by reset", 32'(overflow), 0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired, run hung (all requirements)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule